// File: doc/BRIEF.md
# Cache Line Maintenance Unit with Security Filtering

This block applies a single maintenance action to a single line of a set-associative cache tag and state array. It can clean the line, invalidate it, or clean and invalidate it. A requester names the line in one of two ways. It can give a physical address, which the unit matches against every way of the indexed set. It can instead give an explicit index and way number. The request also carries a security flag. When the requester is secure, it may touch any line. When the requester is non-secure, the per-line non-secure bit limits its reach to non-secure lines only.

The unit accepts a request on a valid/ready handshake. It reads the indexed set of the tag array and picks the target line. When a dirty line is cleaned, it sends the line address out on a valid/ready writeback channel. The writeback address carries the line's non-secure bit as an address attribute. The unit then writes the new valid and dirty bits back into the array and raises `done` for one cycle, which lets upstream logic release its stall.

The tag array model is part of the block. A fill port loads entries into it, and a combinational probe port reads any entry. This makes the state observable at the ports.

Back-pressure works as follows:
- `req_ready` is high only while the unit is idle.
- A request is taken on a cycle where both `req_valid` and `req_ready` are high.
- Once `wb_valid` rises, it stays high, and `wb_addr` and `wb_ns` stay stable, until a cycle where `wb_ready` is high.

Top module: `line_maint_unit`

## Requirements
- R1: After reset every array entry reads invalid and not dirty, `req_ready` is 1, and `wb_valid` and `done` are 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the `done` cycle, and `req_ready` and `wb_valid` are never high together.
- R3: A secure requester (`req_secure`=1) ignores each line's non-secure bit, so secure and non-secure lines can both be targeted.
- R4: A non-secure requester (`req_secure`=0) acts only on lines whose non-secure bit is 1. Any other line is left unchanged and gets no writeback.
- R5: In address mode (`req_by_way`=0) the set index is `req_addr[8:5]` and the tag is `req_addr[31:9]`. A line matches when it is valid, its tag is equal, and it passes the security filter; the lowest-numbered matching way is chosen. With no match, the operation completes with no state change and no writeback.
- R6: In index/way mode (`req_by_way`=1) the set index is `req_addr[8:5]` and the way number is `req_addr[30:28]`. With 8 ways, bit 31 is ignored. The operation acts only if that line is valid and passes the security filter.
- R7: Clean (`req_op`=2'b01) writes back a targeted line that is dirty, then clears dirty and keeps valid at 1. A targeted clean line gets no writeback and ends up unchanged.
- R8: Invalidate (`req_op`=2'b10) clears valid and dirty of the targeted line and never issues a writeback.
- R9: Clean-and-invalidate (`req_op`=2'b11) writes back a targeted dirty line, then clears both valid and dirty.
- R10: The writeback carries `wb_addr` = {line tag, set index, 5'b0} and `wb_ns` = the line's non-secure bit. Exactly one writeback is issued per writing operation, and it is held stable under back-pressure.
- R11: No operation changes a line's tag or non-secure bit.
- R12: `done` is a one-cycle pulse in the first idle cycle after the array update and after any writeback has been accepted.
- R13: Operation code 2'b00 completes with `done` but changes no state and issues no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 2 | 00 none, 01 clean, 10 invalidate, 11 clean-and-invalidate |
| req_by_way | input | 1 | 0 address mode, 1 index/way mode |
| req_addr | input | 32 | Physical address or index/way word |
| req_secure | input | 1 | Requester is secure |
| wb_valid | output | 1 | Writeback request present |
| wb_ready | input | 1 | Writeback consumer accepts |
| wb_addr | output | 32 | Line address to write back |
| wb_ns | output | 1 | Non-secure attribute of the written-back line |
| done | output | 1 | One-cycle completion pulse |
| fill_en | input | 1 | Load an array entry as valid |
| fill_set | input | 4 | Set for the fill |
| fill_way | input | 3 | Way for the fill |
| fill_tag | input | 23 | Tag for the fill |
| fill_ns | input | 1 | Non-secure bit for the fill |
| fill_dirty | input | 1 | Dirty bit for the fill |
| probe_set | input | 4 | Set to observe |
| probe_way | input | 3 | Way to observe |
| probe_valid | output | 1 | Observed valid bit |
| probe_dirty | output | 1 | Observed dirty bit |
| probe_ns | output | 1 | Observed non-secure bit |
| probe_tag | output | 23 | Observed tag |

## Verification
The assertions assume three things about the inputs:
- The fill port is quiet while an operation is in flight.
- `req_valid` is offered only from idle.
- The writeback consumer eventually raises `wb_ready`.

Under these conditions, a maintenance write always lands on a valid line, and a non-secure requester's write always lands on a non-secure line. The stimulus loads lines only between operations. It draws tags from a small pool, so that hits, duplicate tags across ways and misses all occur. It pulls `wb_ready` low at random to exercise the hold rule, but never forever.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_CLEAN  = 2'b01,
    OP_INVAL  = 2'b10,
    OP_CLNINV = 2'b11
  } cmu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_UPD
  } cmu_state_e;
endpackage

// File: rtl/cmu_tag_array.sv
module cmu_tag_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_set,
  input  logic [WAY_W-1:0]      fill_way,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  fill_ns,
  input  logic                  fill_dirty,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_set,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic                  wr_valid,
  input  logic                  wr_dirty,
  input  logic [IDX_W-1:0]      rd_set,
  output logic [WAYS-1:0]       rd_valid,
  output logic [WAYS-1:0]       rd_dirty,
  output logic [WAYS-1:0]       rd_ns,
  output logic [WAYS*TAG_W-1:0] rd_tag,
  input  logic [IDX_W-1:0]      probe_set,
  input  logic [WAY_W-1:0]      probe_way,
  output logic                  probe_valid,
  output logic                  probe_dirty,
  output logic                  probe_ns,
  output logic [TAG_W-1:0]      probe_tag
);
  logic [WAYS-1:0]  v_q   [SETS];
  logic [WAYS-1:0]  d_q   [SETS];
  logic [WAYS-1:0]  ns_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  // state bits: maintenance write first, fill last so a fill wins a clash
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        d_q[s] <= '0;
      end
    end else begin
      if (wr_en) begin
        v_q[wr_set][wr_way] <= wr_valid;
        d_q[wr_set][wr_way] <= wr_dirty;
      end
      if (fill_en) begin
        v_q[fill_set][fill_way] <= 1'b1;
        d_q[fill_set][fill_way] <= fill_dirty;
      end
    end
  end

  // identity bits: only a fill may change them
  always_ff @(posedge clk) begin
    if (fill_en) begin
      ns_q[fill_set][fill_way]  <= fill_ns;
      tag_q[fill_set][fill_way] <= fill_tag;
    end
  end

  assign rd_valid = v_q[rd_set];
  assign rd_dirty = d_q[rd_set];
  assign rd_ns    = ns_q[rd_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd_tag
    assign rd_tag[w*TAG_W +: TAG_W] = tag_q[rd_set][w];
  end

  assign probe_valid = v_q[probe_set][probe_way];
  assign probe_dirty = d_q[probe_set][probe_way];
  assign probe_ns    = ns_q[probe_set][probe_way];
  assign probe_tag   = tag_q[probe_set][probe_way];

  // R5 R6
  wr_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> v_q[wr_set][wr_way]);
endmodule

// File: rtl/cmu_lookup.sv
module cmu_lookup #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 23,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  by_way,
  input  logic                  secure,
  input  logic [TAG_W-1:0]      key_tag,
  input  logic [WAY_W-1:0]      key_way,
  input  logic [WAYS-1:0]       ent_valid,
  input  logic [WAYS-1:0]       ent_dirty,
  input  logic [WAYS-1:0]       ent_ns,
  input  logic [WAYS*TAG_W-1:0] ent_tag,
  output logic                  found,
  output logic [WAY_W-1:0]      way,
  output logic                  dirty,
  output logic                  ns,
  output logic [TAG_W-1:0]      tag
);
  logic [WAYS-1:0] elig;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic addr_match;
    assign addr_match = by_way ? (key_way == WAY_W'(w))
                               : (ent_tag[w*TAG_W +: TAG_W] == key_tag);
    assign elig[w] = ent_valid[w] && (secure || ent_ns[w]) && addr_match;
  end

  // lowest eligible way wins
  always_comb begin
    found = 1'b0;
    way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (elig[w]) begin
        found = 1'b1;
        way   = WAY_W'(w);
      end
    end
  end

  assign dirty = ent_dirty[way];
  assign ns    = ent_ns[way];
  assign tag   = ent_tag[way*TAG_W +: TAG_W];
endmodule

// File: rtl/cmu_ctrl.sv
module cmu_ctrl
  import cmu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_LSB = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_by_way,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  output logic [IDX_W-1:0]  rd_set,
  input  logic [WAYS-1:0]   rd_ns,
  output logic              lk_by_way,
  output logic              lk_secure,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [WAY_W-1:0]  lk_way,
  input  logic              sel_found,
  input  logic [WAY_W-1:0]  sel_way,
  input  logic              sel_dirty,
  input  logic              sel_ns,
  input  logic [TAG_W-1:0]  sel_tag,
  output logic              wr_en,
  output logic [WAY_W-1:0]  wr_way,
  output logic              wr_valid,
  output logic              wr_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              wb_ns,
  output logic              done
);
  cmu_state_e       state_q;
  cmu_op_e          op_q;
  logic             byway_q, sec_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] ktag_q;
  logic [WAY_W-1:0] kway_q;
  logic             found_q, ns_q, done_q;
  logic [WAY_W-1:0] way_q;
  logic [TAG_W-1:0] ltag_q;
  logic             needs_wb;

  assign req_ready = (state_q == ST_IDLE);
  assign needs_wb  = sel_found && sel_dirty && (op_q == OP_CLEAN || op_q == OP_CLNINV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      byway_q <= 1'b0;
      sec_q   <= 1'b0;
      idx_q   <= '0;
      ktag_q  <= '0;
      kway_q  <= '0;
      found_q <= 1'b0;
      way_q   <= '0;
      ns_q    <= 1'b0;
      ltag_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_UPD);
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          op_q    <= cmu_op_e'(req_op);
          byway_q <= req_by_way;
          sec_q   <= req_secure;
          idx_q   <= req_addr[OFF_W +: IDX_W];
          ktag_q  <= req_addr[ADDR_W-1 -: TAG_W];
          kway_q  <= req_addr[WAY_LSB +: WAY_W];
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          found_q <= sel_found && (op_q != OP_NONE);
          way_q   <= sel_way;
          ns_q    <= sel_ns;
          ltag_q  <= sel_tag;
          state_q <= needs_wb ? ST_WB : ST_UPD;
        end
        ST_WB:  if (wb_ready) state_q <= ST_UPD;
        ST_UPD: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_set    = idx_q;
  assign lk_by_way = byway_q;
  assign lk_secure = sec_q;
  assign lk_tag    = ktag_q;
  assign lk_way    = kway_q;

  assign wr_en    = (state_q == ST_UPD) && found_q;
  assign wr_way   = way_q;
  assign wr_valid = (op_q == OP_CLEAN);
  assign wr_dirty = 1'b0;

  assign wb_valid = (state_q == ST_WB);
  assign wb_addr  = {ltag_q, idx_q, {OFF_W{1'b0}}};
  assign wb_ns    = ns_q;
  assign done     = done_q;

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_ns));
  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, wb_valid}));
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  // R4
  ns_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !sec_q |-> rd_ns[way_q]);
  // R8
  inval_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> op_q != OP_INVAL && op_q != OP_NONE);
endmodule

// File: rtl/line_maint_unit.sv
module line_maint_unit #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_by_way,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              wb_ns,
  output logic              done,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_ns,
  input  logic              fill_dirty,
  input  logic [IDX_W-1:0]  probe_set,
  input  logic [WAY_W-1:0]  probe_way,
  output logic              probe_valid,
  output logic              probe_dirty,
  output logic              probe_ns,
  output logic [TAG_W-1:0]  probe_tag
);
  logic [IDX_W-1:0]      rd_set;
  logic [WAYS-1:0]       rd_valid, rd_dirty, rd_ns;
  logic [WAYS*TAG_W-1:0] rd_tag;
  logic                  lk_by_way, lk_secure;
  logic [TAG_W-1:0]      lk_tag, sel_tag;
  logic [WAY_W-1:0]      lk_way, sel_way, wr_way;
  logic                  sel_found, sel_dirty, sel_ns;
  logic                  wr_en, wr_valid, wr_dirty;

  cmu_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_array (
    .clk, .rst_n,
    .fill_en, .fill_set, .fill_way, .fill_tag, .fill_ns, .fill_dirty,
    .wr_en, .wr_set(rd_set), .wr_way, .wr_valid, .wr_dirty,
    .rd_set, .rd_valid, .rd_dirty, .rd_ns, .rd_tag,
    .probe_set, .probe_way, .probe_valid, .probe_dirty, .probe_ns, .probe_tag
  );

  cmu_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .by_way(lk_by_way), .secure(lk_secure), .key_tag(lk_tag), .key_way(lk_way),
    .ent_valid(rd_valid), .ent_dirty(rd_dirty), .ent_ns(rd_ns), .ent_tag(rd_tag),
    .found(sel_found), .way(sel_way), .dirty(sel_dirty), .ns(sel_ns), .tag(sel_tag)
  );

  cmu_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_op, .req_by_way, .req_addr, .req_secure,
    .rd_set, .rd_ns,
    .lk_by_way, .lk_secure, .lk_tag, .lk_way,
    .sel_found, .sel_way, .sel_dirty, .sel_ns, .sel_tag,
    .wr_en, .wr_way, .wr_valid, .wr_dirty,
    .wb_valid, .wb_ready, .wb_addr, .wb_ns, .done
  );
endmodule

// File: tb/line_maint_unit_bench.sv
module line_maint_unit_bench;
  localparam int SETS = 16, WAYS = 8, TAG_W = 23;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_by_way = 1'b0, req_secure = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic        wb_ready = 1'b1;
  logic        req_ready, wb_valid, wb_ns, done;
  logic [31:0] wb_addr;
  logic        fill_en = 1'b0, fill_ns = 1'b0, fill_dirty = 1'b0;
  logic [3:0]  fill_set = '0, probe_set = '0;
  logic [2:0]  fill_way = '0, probe_way = '0;
  logic [22:0] fill_tag = '0;
  logic        probe_valid, probe_dirty, probe_ns;
  logic [22:0] probe_tag;

  int checks = 0, fails = 0, cyc = 0;
  int force_stall = 0;

  logic             mv [SETS][WAYS];
  logic             md [SETS][WAYS];
  logic             mns[SETS][WAYS];
  logic [TAG_W-1:0] mtg[SETS][WAYS];

  line_maint_unit u_line_maint_unit (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_by_way, .req_addr, .req_secure,
    .wb_valid, .wb_ready, .wb_addr, .wb_ns, .done,
    .fill_en, .fill_set, .fill_way, .fill_tag, .fill_ns, .fill_dirty,
    .probe_set, .probe_way, .probe_valid, .probe_dirty, .probe_ns, .probe_tag
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int s, input int w, input logic [TAG_W-1:0] t,
                      input bit ns, input bit d);
    @(negedge clk);
    fill_en = 1'b1; fill_set = 4'(s); fill_way = 3'(w);
    fill_tag = t; fill_ns = ns; fill_dirty = d;
    @(negedge clk);
    fill_en = 1'b0;
    mv[s][w] = 1'b1; md[s][w] = d; mns[s][w] = ns; mtg[s][w] = t;
  endtask

  function automatic int pick(input bit byw, input logic [31:0] a, input bit sec);
    int s = int'(a[8:5]);
    for (int w = 0; w < WAYS; w++)
      if (mv[s][w] && (sec || mns[s][w]) &&
          (byw ? (w == int'(a[30:28])) : (mtg[s][w] == a[31:9])))
        return w;
    return -1;
  endfunction

  task automatic run_op(input logic [1:0] op, input bit byw,
                        input logic [31:0] a, input bit sec, input string req);
    int s = int'(a[8:5]);
    int w = pick(byw, a, sec);
    bit exp_wb = (w >= 0) && (op == 2'b01 || op == 2'b11) && md[s][w];
    int wbn = 0;
    logic [31:0] got_addr = '0;
    logic got_ns = 1'b0;
    bit seen_done = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_op = op; req_by_way = byw; req_addr = a; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 64'd0);
    for (int i = 0; i < 64 && !seen_done; i++) begin
      wb_ready = (force_stall > 0) ? 1'b0 : 1'($urandom_range(0, 3) != 0);
      if (force_stall > 0) force_stall--;
      #1;
      if (wb_valid && wb_ready) begin
        wbn++; got_addr = wb_addr; got_ns = wb_ns;
      end
      if (done) seen_done = 1'b1;
      else @(negedge clk);
    end
    wb_ready = 1'b1;
    check(seen_done, "R12", {req, " done pulse"}, 64'(seen_done), 64'd1);
    check(wbn == (exp_wb ? 1 : 0), req, "writeback count", 64'(wbn), 64'(exp_wb));
    if (exp_wb) begin
      check(got_addr == {mtg[s][w], 4'(s), 5'b0}, "R10", "wb address",
            64'(got_addr), 64'({mtg[s][w], 4'(s), 5'b0}));
      check(got_ns == mns[s][w], "R10", "wb ns", 64'(got_ns), 64'(mns[s][w]));
    end
    if (w >= 0 && op != 2'b00) begin
      if (op != 2'b01) mv[s][w] = 1'b0;
      md[s][w] = 1'b0;
    end
    @(negedge clk);
    check(done == 1'b0, "R12", "done one cycle", 64'(done), 64'd0);
    for (int k = 0; k < WAYS; k++) begin
      probe_set = 4'(s); probe_way = 3'(k);
      #1;
      check(probe_valid == mv[s][k] && (!mv[s][k] || probe_dirty == md[s][k]),
            req, $sformatf("state way %0d", k),
            64'({probe_valid, probe_dirty}), 64'({mv[s][k], md[s][k]}));
      if (mv[s][k])
        check(probe_ns == mns[s][k] && probe_tag == mtg[s][k], "R11",
              $sformatf("identity way %0d", k),
              64'({probe_ns, probe_tag}), 64'({mns[s][k], mtg[s][k]}));
    end
  endtask

  function automatic logic [31:0] pa(input logic [TAG_W-1:0] t, input int s);
    return {t, 4'(s), 5'h0};
  endfunction

  function automatic logic [31:0] iw(input int w, input int s, input bit b31);
    return {b31, 3'(w), 19'h0, 4'(s), 5'h0};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 0; md[s][w] = 0; mns[s][w] = 0; mtg[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !wb_valid && !done, "R1", "idle outputs",
          64'({req_ready, wb_valid, done}), 64'b100);
    for (int s = 0; s < SETS; s += 5) begin
      probe_set = 4'(s); probe_way = 3'(s % WAYS); #1;
      check(!probe_valid && !probe_dirty, "R1", "entry cleared",
            64'({probe_valid, probe_dirty}), 64'd0);
    end

    // R3 R7: secure clean of a dirty secure line, with stalled writeback
    fill(2, 3, 23'h55, 1'b0, 1'b1);
    force_stall = 4;
    run_op(2'b01, 1'b0, pa(23'h55, 2), 1'b1, "R7");
    // R7: clean of a now-clean line, no writeback
    run_op(2'b01, 1'b0, pa(23'h55, 2), 1'b1, "R7");
    // R4: non-secure requester against a secure dirty line
    fill(4, 0, 23'h10, 1'b0, 1'b1);
    run_op(2'b11, 1'b0, pa(23'h10, 4), 1'b0, "R4");
    run_op(2'b11, 1'b1, iw(0, 4, 1'b0), 1'b0, "R4");
    // R9: non-secure clean-and-invalidate of a non-secure dirty line
    fill(5, 6, 23'h7A, 1'b1, 1'b1);
    run_op(2'b11, 1'b0, pa(23'h7A, 5), 1'b0, "R9");
    // R8: invalidate dirty line, no writeback
    fill(6, 1, 23'h3, 1'b1, 1'b1);
    run_op(2'b10, 1'b0, pa(23'h3, 6), 1'b1, "R8");
    // R5: miss
    fill(7, 2, 23'h9, 1'b1, 1'b1);
    run_op(2'b11, 1'b0, pa(23'h8, 7), 1'b1, "R5");
    // R6: index/way with bit 31 set (ignored for 8 ways)
    run_op(2'b01, 1'b1, iw(2, 7, 1'b1), 1'b0, "R6");
    // R5 R3: same tag in secure way 1 and non-secure way 4
    fill(9, 1, 23'h44, 1'b0, 1'b1);
    fill(9, 4, 23'h44, 1'b1, 1'b1);
    run_op(2'b11, 1'b0, pa(23'h44, 9), 1'b0, "R5");
    run_op(2'b11, 1'b0, pa(23'h44, 9), 1'b1, "R3");
    // R13: op none on a dirty line
    fill(11, 5, 23'h21, 1'b1, 1'b1);
    run_op(2'b00, 1'b1, iw(5, 11, 1'b0), 1'b1, "R13");

    // random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 1) == 1)
        fill(int'($urandom_range(0, SETS - 1)), int'($urandom_range(0, WAYS - 1)),
             23'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 1) == 1)
        run_op(2'($urandom_range(0, 3)), 1'b0,
               pa(23'($urandom_range(0, 3)), int'($urandom_range(0, SETS - 1))),
               1'($urandom_range(0, 1)), "R5");
      else
        run_op(2'($urandom_range(0, 3)), 1'b1,
               iw(int'($urandom_range(0, WAYS - 1)), int'($urandom_range(0, SETS - 1)),
                  1'($urandom_range(0, 1))),
               1'($urandom_range(0, 1)), "R6");
    end
    finish_run();
  end
endmodule